// File: doc/BRIEF.md
# Addressing Mode Effective Address Unit

This block turns a decoded operand addressing mode into a 32-bit effective address. The caller presents the mode code, the eight general registers, the dedicated registers (program counter, both stack pointers with a selector, static base, frame pointer), a link-table base, two signed displacements, an optional index request (register and scale code), the access direction and the operand size, and pulses `start`. Direct modes finish the cycle after `start`. The two indirect modes (pointer through a frame or base register, and pointer through a link-table entry) first fetch a pointer over a request/acknowledge port and then add the second displacement to it.

A top-of-stack access uses the selected stack pointer. A write pushes: the pointer is decremented by the operand size first, and that new value is the address. A read pops: the current pointer is the address and the pointer then advances by the size. The updated pointer is returned for the caller to write back. Illegal combinations end in a fault cycle instead of an address, and no memory request is made.

The controller has four states. IDLE waits for `start` and goes to FAULT on an illegal combination, to FETCH for an indirect mode, and to DONE otherwise. FETCH holds the request until an acknowledge is sampled, then goes to DONE. DONE and FAULT each last one cycle and return to IDLE.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (register relative) gives ea = general register[`reg_sel`] + `disp1`, with `done` high in the cycle after `start` is sampled.
- R2: Mode code 1 (memory space) gives ea = dedicated register + `disp1`. `dsel` picks it: 0 program counter, 1 the current stack pointer (`sp1` when `sp_sel`=1, otherwise `sp0`), 2 static base, 3 frame pointer.
- R3: Mode code 4 (absolute) gives ea = `disp1`. Mode code 6 (immediate) on a read completes with ea = 0 and no memory request.
- R4: Mode code 2 (memory relative) requests a read at dedicated register[`dsel`] + `disp1`, and then gives ea = returned data + `disp2`.
- R5: Mode code 3 (external) requests a read at `link_base` + 4×`disp1`, and then gives ea = returned data + `disp2`.
- R6: Mode code 5 (top of stack) with `is_write`=1 gives ea = sp − `op_bytes` and `sp_new` = ea. With `is_write`=0 it gives ea = sp and `sp_new` = sp + `op_bytes`. In both cases `sp_wr_en` is high with `done`, and `sp_sel_o` echoes the selector.
- R7: With `idx_en`=1, general register[`idx_reg`] shifted left by `idx_scale` (codes 0..3 multiply by 1, 2, 4 or 8) is added to the address the base mode produces.
- R8: The following are illegal: immediate with `is_write`=1; immediate with `idx_en`=1; mode code 7 (a nested index marker); memory relative with `dsel`=0. Each raises `err` together with `done` for one cycle and never raises `mem_req`.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is sampled high. `done` follows in the next cycle.
- R10: `start` is ignored while an access is in progress, and the result belongs to the access that was accepted.
- R11: During reset `done`, `err`, `mem_req` and `sp_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address calculation |
| mode | input | 3 | Addressing mode code |
| dsel | input | 2 | Dedicated register select |
| reg_sel | input | 3 | Base general register |
| gpr_flat | input | 256 | General registers, register i at bits 32i+31:32i |
| pc | input | 32 | Program counter |
| sp0 | input | 32 | Stack pointer 0 |
| sp1 | input | 32 | Stack pointer 1 |
| sp_sel | input | 1 | Current stack pointer select |
| sb | input | 32 | Static base |
| fp | input | 32 | Frame pointer |
| link_base | input | 32 | Current link table base |
| disp1 | input | 32 | First displacement or entry number |
| disp2 | input | 32 | Second displacement |
| idx_en | input | 1 | Apply scaled index |
| idx_reg | input | 3 | Index general register |
| idx_scale | input | 2 | Index shift amount |
| is_write | input | 1 | Operand is written |
| op_bytes | input | 4 | Operand size in bytes |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 32 | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge |
| mem_rdata | input | 32 | Pointer read data |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal combination pulse |
| ea | output | 32 | Effective address |
| sp_wr_en | output | 1 | Stack pointer update valid |
| sp_sel_o | output | 1 | Which stack pointer to update |
| sp_new | output | 32 | Updated stack pointer |

## Verification
Direct modes and faults give their result exactly one cycle after the edge that accepts `start`. Indirect modes raise the request in that cycle and give the result one cycle after the edge where the acknowledge is sampled, so the latency is 2 + the acknowledge delay. The bench reference advances its own state at each rising edge from the same inputs, and it compares every output at the following falling edge. Each check therefore falls in the cycle the result is due. Acknowledge delays of zero and several cycles are both used.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [2:0] {
        AM_REGREL = 3'd0,
        AM_MEMSP  = 3'd1,
        AM_MEMREL = 3'd2,
        AM_EXTERN = 3'd3,
        AM_ABS    = 3'd4,
        AM_TOS    = 3'd5,
        AM_IMM    = 3'd6,
        AM_INDEX  = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        DR_PC = 2'd0,
        DR_SP = 2'd1,
        DR_SB = 2'd2,
        DR_FP = 2'd3
    } dreg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } st_e;
endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NGPR = 8,
    parameter int RIW  = 3,
    parameter int SZW  = 4
) (
    input  logic [2:0]         mode,
    input  logic [1:0]         dsel,
    input  logic [RIW-1:0]     reg_sel,
    input  logic [NGPR*AW-1:0] gpr_flat,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      sp0,
    input  logic [AW-1:0]      sp1,
    input  logic               sp_sel,
    input  logic [AW-1:0]      sb,
    input  logic [AW-1:0]      fp,
    input  logic [AW-1:0]      link_base,
    input  logic [AW-1:0]      disp1,
    input  logic               idx_en,
    input  logic [RIW-1:0]     idx_reg,
    input  logic [1:0]         idx_scale,
    input  logic               is_write,
    input  logic [SZW-1:0]     op_bytes,
    output logic               need_fetch,
    output logic               tos,
    output logic [AW-1:0]      addr,
    output logic [AW-1:0]      idx_term,
    output logic [AW-1:0]      sp_next
);
    logic [AW-1:0] gbase, gidx, sp_cur, dval, size_ext;

    always_comb begin
        gbase    = gpr_flat[int'(reg_sel)*AW +: AW];
        gidx     = gpr_flat[int'(idx_reg)*AW +: AW];
        sp_cur   = sp_sel ? sp1 : sp0;
        size_ext = AW'(op_bytes);
        unique case (dreg_e'(dsel))
            DR_PC:   dval = pc;
            DR_SP:   dval = sp_cur;
            DR_SB:   dval = sb;
            default: dval = fp;
        endcase
        idx_term = idx_en ? (gidx << idx_scale) : '0;
    end

    always_comb begin
        need_fetch = 1'b0;
        tos        = 1'b0;
        addr       = '0;
        sp_next    = sp_cur;
        unique case (am_e'(mode))
            AM_REGREL: addr = gbase + disp1;
            AM_MEMSP:  addr = dval + disp1;
            AM_MEMREL: begin
                need_fetch = 1'b1;
                addr       = dval + disp1;
            end
            AM_EXTERN: begin
                need_fetch = 1'b1;
                addr       = link_base + (disp1 << 2);
            end
            AM_ABS:    addr = disp1;
            AM_TOS: begin
                tos = 1'b1;
                if (is_write) begin
                    addr    = sp_cur - size_ext;
                    sp_next = sp_cur - size_ext;
                end else begin
                    addr    = sp_cur;
                    sp_next = sp_cur + size_ext;
                end
            end
            default:   addr = '0;
        endcase
    end
endmodule

// File: rtl/ea_legal_chk.sv
module ea_legal_chk
    import ea_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] dsel,
    input  logic       is_write,
    input  logic       idx_en,
    output logic       illegal
);
    always_comb begin
        unique case (am_e'(mode))
            AM_INDEX:  illegal = 1'b1;
            AM_IMM:    illegal = is_write | idx_en;
            AM_MEMREL: illegal = (dreg_e'(dsel) == DR_PC);
            default:   illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          illegal,
    input  logic          need_fetch,
    input  logic          tos,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] idx_term,
    input  logic [AW-1:0] disp2,
    input  logic [AW-1:0] sp_next,
    input  logic          sp_sel,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] ea,
    output logic          sp_wr_en,
    output logic          sp_sel_o,
    output logic [AW-1:0] sp_new
);
    st_e           st, st_nx;
    logic [AW-1:0] l_addr, l_idx, l_disp2, l_spn, l_ptr;
    logic          l_fetch, l_tos, l_spsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) begin
                if (illegal)         st_nx = ST_FAULT;
                else if (need_fetch) st_nx = ST_FETCH;
                else                 st_nx = ST_DONE;
            end
            ST_FETCH: if (mem_ack) st_nx = ST_DONE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_addr  <= '0;
            l_idx   <= '0;
            l_disp2 <= '0;
            l_spn   <= '0;
            l_ptr   <= '0;
            l_fetch <= 1'b0;
            l_tos   <= 1'b0;
            l_spsel <= 1'b0;
        end else if (st == ST_IDLE && start) begin
            l_addr  <= addr;
            l_idx   <= idx_term;
            l_disp2 <= disp2;
            l_spn   <= sp_next;
            l_fetch <= need_fetch;
            l_tos   <= tos;
            l_spsel <= sp_sel;
        end else if (st == ST_FETCH && mem_ack) begin
            l_ptr   <= mem_rdata;
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        err      = 1'b0;
        ea       = '0;
        sp_wr_en = 1'b0;
        sp_sel_o = 1'b0;
        sp_new   = '0;
        unique case (st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = l_addr;
            end
            ST_DONE: begin
                done     = 1'b1;
                ea       = (l_fetch ? l_ptr + l_disp2 : l_addr) + l_idx;
                sp_wr_en = l_tos;
                sp_sel_o = l_spsel;
                sp_new   = l_tos ? l_spn : '0;
            end
            ST_FAULT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NGPR = 8,
    parameter int SZW  = 4,
    localparam int RIW = $clog2(NGPR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         mode,
    input  logic [1:0]         dsel,
    input  logic [RIW-1:0]     reg_sel,
    input  logic [NGPR*AW-1:0] gpr_flat,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      sp0,
    input  logic [AW-1:0]      sp1,
    input  logic               sp_sel,
    input  logic [AW-1:0]      sb,
    input  logic [AW-1:0]      fp,
    input  logic [AW-1:0]      link_base,
    input  logic [AW-1:0]      disp1,
    input  logic [AW-1:0]      disp2,
    input  logic               idx_en,
    input  logic [RIW-1:0]     idx_reg,
    input  logic [1:0]         idx_scale,
    input  logic               is_write,
    input  logic [SZW-1:0]     op_bytes,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_ack,
    input  logic [AW-1:0]      mem_rdata,
    output logic               done,
    output logic               err,
    output logic [AW-1:0]      ea,
    output logic               sp_wr_en,
    output logic               sp_sel_o,
    output logic [AW-1:0]      sp_new
);
    logic          need_fetch, tos, illegal;
    logic [AW-1:0] c_addr, c_idx, c_spn;

    ea_addr_calc #(.AW(AW), .NGPR(NGPR), .RIW(RIW), .SZW(SZW)) u_calc (
        .mode(mode), .dsel(dsel), .reg_sel(reg_sel), .gpr_flat(gpr_flat),
        .pc(pc), .sp0(sp0), .sp1(sp1), .sp_sel(sp_sel), .sb(sb), .fp(fp),
        .link_base(link_base), .disp1(disp1), .idx_en(idx_en),
        .idx_reg(idx_reg), .idx_scale(idx_scale), .is_write(is_write),
        .op_bytes(op_bytes), .need_fetch(need_fetch), .tos(tos),
        .addr(c_addr), .idx_term(c_idx), .sp_next(c_spn)
    );

    ea_legal_chk u_legal (
        .mode(mode), .dsel(dsel), .is_write(is_write), .idx_en(idx_en),
        .illegal(illegal)
    );

    ea_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .illegal(illegal),
        .need_fetch(need_fetch), .tos(tos), .addr(c_addr), .idx_term(c_idx),
        .disp2(disp2), .sp_next(c_spn), .sp_sel(sp_sel), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .done(done), .err(err), .ea(ea), .sp_wr_en(sp_wr_en),
        .sp_sel_o(sp_sel_o), .sp_new(sp_new)
    );
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          sp_wr_en
);
    // R8: a fault completes and never comes with a request
    a_r8_fault_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !mem_req));

    // R9: request and address hold until acknowledged
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R9: an acknowledged fetch completes next cycle without fault
    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && !err && !mem_req));

    // R10: a result is a single-cycle pulse
    a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: stack pointer update only with a good completion
    a_r6_sp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |-> (done && !err));
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .err(err), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .sp_wr_en(sp_wr_en)
);

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  dsel = '0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] g [8];
    logic [255:0] gpr_flat;
    logic [31:0] pc = 32'h0000_4000, sp0 = 32'h0000_8000, sp1 = 32'h0001_0000;
    logic        sp_sel = 1'b0;
    logic [31:0] sb = 32'h0002_0000, fp = 32'h0003_0000, link_base = 32'h0005_0000;
    logic [31:0] disp1 = '0, disp2 = '0;
    logic        idx_en = 1'b0;
    logic [2:0]  idx_reg = '0;
    logic [1:0]  idx_scale = '0;
    logic        is_write = 1'b0;
    logic [3:0]  op_bytes = 4'd4;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_rdata, ea, sp_new;
    logic        done, err, sp_wr_en, sp_sel_o;

    int checks = 0, fails = 0, cyc = 0, ack_lat = 0, wcnt = 0;
    int ms = 0;
    logic [31:0] e_ea, e_faddr, e_spn, e_d2, e_idx, last_ea;
    logic        e_tos, e_spsel;
    string       tag = "R1";

    always #2 clk = ~clk;

    always_comb for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = g[i];

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
    endfunction
    assign mem_rdata = memfn(mem_addr);

    ea_unit u0 (.*);

    function automatic logic [31:0] dreg(input logic [1:0] s);
        case (s)
            2'd0: return pc;
            2'd1: return sp_sel ? sp1 : sp0;
            2'd2: return sb;
            default: return fp;
        endcase
    endfunction

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) ms = 0;
        else case (ms)
            0: if (start) begin
                logic ill, fetch;
                logic [31:0] spc, fin, sz;
                ill = (mode == 3'd7) || (mode == 3'd6 && (is_write || idx_en))
                      || (mode == 3'd2 && dsel == 2'd0);
                spc = sp_sel ? sp1 : sp0;
                sz = {28'd0, op_bytes};
                e_idx = idx_en ? g[idx_reg] * (32'd1 << idx_scale) : 32'd0;
                fetch = 1'b0; fin = 32'd0; e_tos = 1'b0; e_spsel = sp_sel;
                e_d2 = disp2;
                case (mode)
                    3'd0: begin fin = g[reg_sel] + disp1; tag = "R1"; end
                    3'd1: begin fin = dreg(dsel) + disp1; tag = "R2"; end
                    3'd2: begin fetch = 1'b1; e_faddr = dreg(dsel) + disp1; tag = "R4"; end
                    3'd3: begin fetch = 1'b1; e_faddr = link_base + disp1 * 4; tag = "R5"; end
                    3'd4: begin fin = disp1; tag = "R3"; end
                    3'd5: begin
                        e_tos = 1'b1; tag = "R6";
                        fin   = is_write ? spc - sz : spc;
                        e_spn = is_write ? spc - sz : spc + sz;
                    end
                    default: begin fin = 32'd0; tag = "R3"; end
                endcase
                if (idx_en) tag = "R7";
                if (ill) tag = "R8";
                e_ea = fin + e_idx;
                ms = ill ? 3 : (fetch ? 1 : 2);
            end
            1: if (mem_ack) begin
                e_ea = memfn(e_faddr) + e_d2 + e_idx;
                ms = 2;
            end
            default: ms = 0;
        endcase
    end

    task automatic chk(input bit ok, input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // acknowledge generator
    always @(negedge clk) begin
        if (mem_req) begin
            mem_ack = (wcnt >= ack_lat);
            wcnt++;
        end else begin
            mem_ack = 1'b0;
            wcnt = 0;
        end
    end

    // per-cycle comparison away from the rising edge
    always @(negedge clk) begin
        string t;
        t = rst_n ? tag : "R11";
        chk(done === (ms >= 2), t, "done", {31'd0, done}, {31'd0, ms >= 2});
        chk(err === (ms == 3), t, "err", {31'd0, err}, {31'd0, ms == 3});
        chk(mem_req === (ms == 1), rst_n ? "R9" : t, "mem_req", {31'd0, mem_req}, {31'd0, ms == 1});
        chk(sp_wr_en === (ms == 2 && e_tos), rst_n ? "R6" : t, "sp_wr_en",
            {31'd0, sp_wr_en}, {31'd0, ms == 2 && e_tos});
        if (ms == 1) chk(mem_addr === e_faddr, t, "mem_addr", mem_addr, e_faddr);
        if (ms == 2) chk(ea === e_ea, t, "ea", ea, e_ea);
        if (ms == 2 && e_tos) begin
            chk(sp_new === e_spn, "R6", "sp_new", sp_new, e_spn);
            chk(sp_sel_o === e_spsel, "R6", "sp_sel_o", {31'd0, sp_sel_o}, {31'd0, e_spsel});
        end
        if (done) last_ea = ea;
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<20000", cyc);
        summary();
    end

    task automatic go();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (ms != 0) @(negedge clk);
    endtask

    task automatic clr();
        idx_en = 1'b0; is_write = 1'b0; dsel = 2'd0; sp_sel = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) g[i] = 32'h0000_1000 * (i + 1) + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        mode = 3'd0; reg_sel = 3'd3; disp1 = 32'h10; go();
        disp1 = 32'hFFFF_FFFC; reg_sel = 3'd7; go();
        // R2 all dedicated registers
        for (int s = 0; s < 4; s++) begin
            mode = 3'd1; dsel = 2'(s); sp_sel = s[0]; disp1 = 32'h24 + s; go();
        end
        clr();
        // R3
        mode = 3'd4; disp1 = 32'hDEAD_0000; go();
        mode = 3'd6; go();
        // R4 with zero and longer acknowledge delays
        mode = 3'd2; dsel = 2'd2; disp1 = 32'h40; disp2 = 32'h8; ack_lat = 0; go();
        dsel = 2'd3; disp1 = 32'hFFFF_FFF0; disp2 = 32'h100; ack_lat = 3; go();
        dsel = 2'd1; sp_sel = 1'b1; ack_lat = 1; go();
        clr();
        // R5
        mode = 3'd3; disp1 = 32'd5; disp2 = 32'h20; ack_lat = 2; go();
        disp1 = 32'd0; disp2 = 32'h0; ack_lat = 0; go();
        // R6 pop and push on both pointers and sizes
        mode = 3'd5; is_write = 1'b0; op_bytes = 4'd4; go();
        is_write = 1'b1; sp_sel = 1'b1; op_bytes = 4'd8; go();
        is_write = 1'b1; sp_sel = 1'b0; op_bytes = 4'd1; go();
        is_write = 1'b0; sp_sel = 1'b1; op_bytes = 4'd2; go();
        clr();
        // R7 scaled index on several bases
        mode = 3'd0; reg_sel = 3'd1; disp1 = 32'h4; idx_en = 1'b1; idx_reg = 3'd2; idx_scale = 2'd3; go();
        mode = 3'd3; disp1 = 32'd3; disp2 = 32'h4; idx_reg = 3'd5; idx_scale = 2'd1; ack_lat = 1; go();
        mode = 3'd5; is_write = 1'b1; idx_reg = 3'd0; idx_scale = 2'd2; go();
        mode = 3'd4; disp1 = 32'h100; idx_reg = 3'd6; idx_scale = 2'd0; go();
        clr();
        // R8 illegal combinations
        mode = 3'd6; is_write = 1'b1; go();
        clr(); mode = 3'd6; idx_en = 1'b1; go();
        clr(); mode = 3'd7; go();
        mode = 3'd2; dsel = 2'd0; go();
        clr();
        // R10 start held high during a fetch with other inputs
        mode = 3'd2; dsel = 2'd2; disp1 = 32'h80; disp2 = 32'h3; ack_lat = 4;
        @(negedge clk); start = 1'b1;
        @(negedge clk); mode = 3'd4; disp1 = 32'h1234;
        repeat (2) @(negedge clk);
        start = 1'b0;
        while (ms != 0) @(negedge clk);
        chk(last_ea === memfn(32'h0002_0080) + 32'h3, "R10", "ea of accepted access",
            last_ea, memfn(32'h0002_0080) + 32'h3);
        // R11 reset mid-access
        mode = 3'd3; disp1 = 32'd1; ack_lat = 5;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        summary();
    end
endmodule